// File: doc/BRIEF.md
# Receive Frame Buffer Formatter

This block takes one incoming Ethernet frame and lays it out in a packet buffer in the layout that the controller's receive path expects. A frame announces itself with a start strobe that carries its byte count. The payload bytes then follow one per valid cycle, and a last flag marks the final byte. At the start strobe the block checks the receive configuration and works out the stored size. If the frame can be taken, it claims the buffer number that the allocator offers.

While the payload streams in, the block writes the bytes through a byte-wide write port into the claimed buffer. It then adds zero padding, the CRC-32 when the CRC is kept, and a two-byte trailer. It writes the four-byte header last. Finally it pushes the buffer number toward the receive queue and raises the receive-interrupt set pulse for one cycle.

A frame is dropped when receive is disabled, soft reset is active, the stored size would not fit the buffer, no buffer is free, or the formatter is still busy with an earlier frame. A dropped frame leaves no trace in storage.

Top module: `rx_frame_formatter`

## Requirements
- R1: A start is refused (frmDrop pulses in the start cycle, allocTake stays low, nothing is written) when cfgRxEnable is low or cfgSoftReset is high.
- R2: Buffer bytes 2 (low) and 3 (high) hold the stored size: the frame length rounded down to even but at least 64, plus 6, plus 4 more when cfgStripCrc is low. Exactly that many bytes are written, at addresses 0 up to the size minus 1.
- R3: A start is refused when the stored size exceeds BUF_BYTES (2048) or when allocValid is low. A size of exactly 2048 is accepted.
- R4: Bytes 0 (low) and 1 (high) hold a status word. Bit 11 is set when the length exceeds 1518, bit 12 is set when the length is odd, and all other bits are zero.
- R5: Payload starts at byte 4. A frame shorter than 64 bytes stores all its bytes, including an odd last one, and is then zero-padded to 64 payload bytes. A longer frame stores its even-length part.
- R6: When cfgStripCrc is low, a CRC-32 follows the payload, least significant byte first. It uses the reflected polynomial 0xEDB88320, starts from all ones and is inverted at the end. It covers the padded 64 bytes for short frames and every frame byte otherwise.
- R7: For a frame of at least 64 bytes with odd length, the last two bytes are the odd final frame byte and then 0x60. Every other frame ends in 0x00 and then 0x40.
- R8: After the last buffer write, rxPush and rcvIrqSet pulse together for one cycle, with rxPushNum equal to the claimed buffer number.
- R9: A start that arrives while a frame is in progress, including the push cycle, is refused with frmDrop. It does not disturb the frame in progress, and a start in the cycle after the push is accepted.
- R10: Payload bytes that arrive while no frame has been accepted cause no write and no push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgRxEnable | input | 1 | Receive enabled |
| cfgSoftReset | input | 1 | Soft reset active; refuses frames |
| cfgStripCrc | input | 1 | Do not store a CRC |
| frmStart | input | 1 | Frame start strobe |
| frmLen | input | LEN_W | Frame byte count, valid with frmStart |
| frmValid | input | 1 | Payload byte valid |
| frmData | input | 8 | Payload byte |
| frmLast | input | 1 | Final payload byte |
| allocValid | input | 1 | Allocator offers a free buffer |
| allocNum | input | NUM_W | Offered buffer number |
| allocTake | output | 1 | Offered buffer claimed this cycle |
| frmDrop | output | 1 | Start refused this cycle |
| memWrEn | output | 1 | Buffer write strobe |
| memBuf | output | NUM_W | Buffer being written |
| memAddr | output | ADDR_W | Byte address inside the buffer |
| memData | output | 8 | Byte written |
| rxPush | output | 1 | Push buffer number into receive queue |
| rxPushNum | output | NUM_W | Buffer number pushed |
| rcvIrqSet | output | 1 | Set the receive interrupt bit |

## Verification
Two functions can fall in the same cycle: completion of one frame, with its queue push, and the start of the next frame. The bench holds a new start high from the last payload byte of one frame onward, so the start is present in the push cycle. It then expects a refusal in that cycle and acceptance in the following one. A start poked into the middle of a payload stream must likewise be refused while the stored image of the running frame still matches the reference byte for byte.

// File: rtl/rxfmt_pkg.sv
package rxfmt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DATA, ST_PAD, ST_CRC, ST_TRL0, ST_TRL1, ST_HDR, ST_DONE
  } fmtState_e;

  typedef enum logic [2:0] {
    SEL_IN, SEL_ZERO, SEL_CRC, SEL_ODD, SEL_MARK_ODD, SEL_MARK_EVEN, SEL_HDR
  } byteSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     crcInit;
    logic     crcStep;
    logic     crcZero;
    logic     holdOdd;
    byteSel_e sel;
    logic [1:0] idx;
  } fmtStrobe_t;

  localparam logic [7:0] MARK_ODD  = 8'h60;
  localparam logic [7:0] MARK_EVEN = 8'h40;

endpackage

// File: rtl/rxfmt_ctrl.sv
module rxfmt_ctrl
  import rxfmt_pkg::*;
#(
  parameter int NUM_W      = 2,
  parameter int ADDR_W     = 11,
  parameter int LEN_W      = 12,
  parameter int BUF_BYTES  = 2048,
  parameter int MIN_FRAME  = 64,
  parameter int LONG_LIMIT = 1518
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgRxEnable,
  input  logic              cfgSoftReset,
  input  logic              cfgStripCrc,
  input  logic              frmStart,
  input  logic [LEN_W-1:0]  frmLen,
  input  logic              frmValid,
  input  logic              frmLast,
  input  logic              allocValid,
  input  logic [NUM_W-1:0]  allocNum,
  output logic              allocTake,
  output logic              frmDrop,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [NUM_W-1:0]  memBuf,
  output logic [31:0]       hdrWord,
  output fmtStrobe_t        stb,
  output logic              rxPush,
  output logic [NUM_W-1:0]  rxPushNum,
  output logic              rcvIrqSet
);

  localparam int PKT_W = LEN_W + 1;
  localparam logic [ADDR_W-1:0] DATA_BASE = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] PAD_END   = ADDR_W'(4 + MIN_FRAME - 1);

  function automatic logic [PKT_W-1:0] pktSizeOf(input logic [LEN_W-1:0] len,
                                                 input logic strip);
    logic [PKT_W-1:0] dl;
    if (len < LEN_W'(MIN_FRAME)) dl = PKT_W'(MIN_FRAME);
    else                         dl = {1'b0, len[LEN_W-1:1], 1'b0};
    return dl + PKT_W'(6) + (strip ? PKT_W'(0) : PKT_W'(4));
  endfunction

  fmtState_e         state, stateNext;
  logic [LEN_W-1:0]  lenQ;
  logic              stripQ;
  logic [NUM_W-1:0]  bufQ;
  logic [PKT_W-1:0]  pktQ;
  logic [ADDR_W-1:0] ptr, ptrNext;
  logic [1:0]        k, kNext;
  logic [PKT_W-1:0]  startPkt;
  logic              startOk;
  logic              longOdd;
  logic [15:0]       pkt16;
  logic [7:0]        statHi;

  assign startPkt = pktSizeOf(frmLen, cfgStripCrc);
  assign startOk  = (state == ST_IDLE) && frmStart && cfgRxEnable && !cfgSoftReset
                    && allocValid && (startPkt <= PKT_W'(BUF_BYTES));
  assign longOdd  = lenQ[0] && (lenQ >= LEN_W'(MIN_FRAME));

  assign allocTake = startOk;
  assign frmDrop   = frmStart && !startOk;
  assign memBuf    = bufQ;
  assign rxPush    = (state == ST_DONE);
  assign rcvIrqSet = (state == ST_DONE);
  assign rxPushNum = bufQ;

  assign pkt16   = 16'(pktQ);
  assign statHi  = {3'b000, lenQ[0], (lenQ > LEN_W'(LONG_LIMIT)), 3'b000};
  assign hdrWord = {pkt16[15:8], pkt16[7:0], statHi, 8'h00};

  always_comb begin
    stb       = '0;
    memWrEn   = 1'b0;
    memAddr   = ptr;
    stateNext = state;
    ptrNext   = ptr;
    kNext     = k;
    case (state)
      ST_IDLE: begin
        if (startOk) begin
          stateNext   = ST_DATA;
          stb.crcInit = 1'b1;
        end
      end
      ST_DATA: begin
        if (frmValid) begin
          stb.crcStep = 1'b1;
          stb.sel     = SEL_IN;
          if (longOdd && frmLast) begin
            stb.holdOdd = 1'b1;
          end else begin
            memWrEn = 1'b1;
            ptrNext = ptr + ADDR_W'(1);
          end
          if (frmLast) begin
            if (ptrNext <= PAD_END) stateNext = ST_PAD;
            else                    stateNext = stripQ ? ST_TRL0 : ST_CRC;
          end
        end
      end
      ST_PAD: begin
        memWrEn     = 1'b1;
        stb.sel     = SEL_ZERO;
        stb.crcStep = 1'b1;
        stb.crcZero = 1'b1;
        ptrNext     = ptr + ADDR_W'(1);
        if (ptr == PAD_END) stateNext = stripQ ? ST_TRL0 : ST_CRC;
      end
      ST_CRC: begin
        memWrEn = 1'b1;
        stb.sel = SEL_CRC;
        stb.idx = k;
        ptrNext = ptr + ADDR_W'(1);
        kNext   = k + 2'd1;
        if (k == 2'd3) begin
          stateNext = ST_TRL0;
          kNext     = 2'd0;
        end
      end
      ST_TRL0: begin
        memWrEn   = 1'b1;
        stb.sel   = longOdd ? SEL_ODD : SEL_ZERO;
        ptrNext   = ptr + ADDR_W'(1);
        stateNext = ST_TRL1;
      end
      ST_TRL1: begin
        memWrEn   = 1'b1;
        stb.sel   = longOdd ? SEL_MARK_ODD : SEL_MARK_EVEN;
        stateNext = ST_HDR;
        kNext     = 2'd0;
      end
      ST_HDR: begin
        memWrEn = 1'b1;
        memAddr = ADDR_W'(k);
        stb.sel = SEL_HDR;
        stb.idx = k;
        kNext   = k + 2'd1;
        if (k == 2'd3) begin
          stateNext = ST_DONE;
          kNext     = 2'd0;
        end
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      lenQ   <= '0;
      stripQ <= 1'b0;
      bufQ   <= '0;
      pktQ   <= '0;
      ptr    <= DATA_BASE;
      k      <= 2'd0;
    end else begin
      state <= stateNext;
      if (startOk) begin
        lenQ   <= frmLen;
        stripQ <= cfgStripCrc;
        bufQ   <= allocNum;
        pktQ   <= startPkt;
        ptr    <= DATA_BASE;
        k      <= 2'd0;
      end else begin
        ptr <= ptrNext;
        k   <= kNext;
      end
    end
  end

  AST_REFUSE_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && frmStart && (!cfgRxEnable || cfgSoftReset)) |=> (state == ST_IDLE)); // R1
  AST_WRITE_BELOW_SIZE: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (PKT_W'(memAddr) < pktQ)); // R2
  AST_BUFFER_FITS: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> (pktQ <= PKT_W'(BUF_BYTES))); // R3
  AST_PUSH_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rxPush |=> !rxPush); // R8
  AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && frmStart) |-> !allocTake); // R9
  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !memWrEn); // R10

endmodule

// File: rtl/rxfmt_dpath.sv
module rxfmt_dpath
  import rxfmt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  fmtStrobe_t  stb,
  input  logic [7:0]  frmData,
  input  logic [31:0] hdrWord,
  output logic [7:0]  memData
);

  localparam logic [31:0] CRC_POLY = 32'hEDB88320;

  function automatic logic [31:0] crcByte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction

  logic [31:0] crcReg;
  logic [31:0] crcOut;
  logic [7:0]  oddReg;

  assign crcOut = ~crcReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg <= '1;
      oddReg <= 8'h00;
    end else begin
      if (stb.crcInit)      crcReg <= '1;
      else if (stb.crcStep) crcReg <= crcByte(crcReg, stb.crcZero ? 8'h00 : frmData);
      if (stb.holdOdd)      oddReg <= frmData;
    end
  end

  always_comb begin
    case (stb.sel)
      SEL_IN:        memData = frmData;
      SEL_ZERO:      memData = 8'h00;
      SEL_CRC:       memData = crcOut[{stb.idx, 3'b000} +: 8];
      SEL_ODD:       memData = oddReg;
      SEL_MARK_ODD:  memData = MARK_ODD;
      SEL_MARK_EVEN: memData = MARK_EVEN;
      SEL_HDR:       memData = hdrWord[{stb.idx, 3'b000} +: 8];
      default:       memData = 8'h00;
    endcase
  end

  AST_CRC_SEEDED: assert property (@(posedge clk) disable iff (!rstN)
    stb.crcInit |=> (crcReg == 32'hFFFFFFFF)); // R6
  AST_ODD_HELD: assert property (@(posedge clk) disable iff (!rstN)
    stb.holdOdd |=> (oddReg == $past(frmData))); // R7

endmodule

// File: rtl/rx_frame_formatter.sv
module rx_frame_formatter
  import rxfmt_pkg::*;
#(
  parameter int NUM_BUFS   = 4,
  parameter int BUF_BYTES  = 2048,
  parameter int LEN_W      = 12,
  parameter int MIN_FRAME  = 64,
  parameter int LONG_LIMIT = 1518,
  localparam int NUM_W     = $clog2(NUM_BUFS),
  localparam int ADDR_W    = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgRxEnable,
  input  logic              cfgSoftReset,
  input  logic              cfgStripCrc,
  input  logic              frmStart,
  input  logic [LEN_W-1:0]  frmLen,
  input  logic              frmValid,
  input  logic [7:0]        frmData,
  input  logic              frmLast,
  input  logic              allocValid,
  input  logic [NUM_W-1:0]  allocNum,
  output logic              allocTake,
  output logic              frmDrop,
  output logic              memWrEn,
  output logic [NUM_W-1:0]  memBuf,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData,
  output logic              rxPush,
  output logic [NUM_W-1:0]  rxPushNum,
  output logic              rcvIrqSet
);

  fmtStrobe_t  stb;
  logic [31:0] hdrWord;

  rxfmt_ctrl #(
    .NUM_W(NUM_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BUF_BYTES(BUF_BYTES),
    .MIN_FRAME(MIN_FRAME), .LONG_LIMIT(LONG_LIMIT)
  ) i_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgRxEnable(cfgRxEnable), .cfgSoftReset(cfgSoftReset), .cfgStripCrc(cfgStripCrc),
    .frmStart(frmStart), .frmLen(frmLen), .frmValid(frmValid), .frmLast(frmLast),
    .allocValid(allocValid), .allocNum(allocNum), .allocTake(allocTake), .frmDrop(frmDrop),
    .memWrEn(memWrEn), .memAddr(memAddr), .memBuf(memBuf), .hdrWord(hdrWord), .stb(stb),
    .rxPush(rxPush), .rxPushNum(rxPushNum), .rcvIrqSet(rcvIrqSet)
  );

  rxfmt_dpath i_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .frmData(frmData),
    .hdrWord(hdrWord), .memData(memData)
  );

endmodule

// File: tb/test_rx_frame_formatter.sv
module test_rx_frame_formatter;

  localparam int CLK_PERIOD = 10;
  localparam int NB         = 4;
  localparam int BUFB       = 2048;
  localparam int LW         = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgRxEnable = 1'b0, cfgSoftReset = 1'b0, cfgStripCrc = 1'b0;
  logic frmStart = 1'b0;
  logic [LW-1:0] frmLen = '0;
  logic frmValid = 1'b0;
  logic [7:0] frmData = 8'h00;
  logic frmLast = 1'b0;
  logic allocValid = 1'b0;
  logic [1:0] allocNum = 2'd0;
  logic allocTake, frmDrop, memWrEn, rxPush, rcvIrqSet;
  logic [1:0] memBuf, rxPushNum;
  logic [10:0] memAddr;
  logic [7:0] memData;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_frame_formatter i_rx_frame_formatter (
    .clk(clk), .rstN(rstN), .cfgRxEnable(cfgRxEnable), .cfgSoftReset(cfgSoftReset),
    .cfgStripCrc(cfgStripCrc), .frmStart(frmStart), .frmLen(frmLen), .frmValid(frmValid),
    .frmData(frmData), .frmLast(frmLast), .allocValid(allocValid), .allocNum(allocNum),
    .allocTake(allocTake), .frmDrop(frmDrop), .memWrEn(memWrEn), .memBuf(memBuf),
    .memAddr(memAddr), .memData(memData), .rxPush(rxPush), .rxPushNum(rxPushNum),
    .rcvIrqSet(rcvIrqSet)
  );

  int total = 0;
  int bad = 0;
  logic [7:0] img [NB][BUFB];
  logic [7:0] expImg [$];
  int expBuf = 0;
  int expPkt = 0;
  bit busyExp = 1'b0;
  int idleWrites = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exv);
    end
  endtask

  function automatic logic [7:0] dbyte(input int i, input int seed);
    return 8'((i * 7 + seed) & 255);
  endfunction

  // behavioural reference image of one stored frame
  task automatic prep(input int len, input bit strip, input int b, input int seed);
    logic [7:0] pay [$];
    logic [31:0] c;
    int dl, pkt;
    logic [7:0] hi;
    bit lodd;
    pay = {};
    expImg = {};
    dl   = (len < 64) ? 64 : (len & ~1);
    pkt  = dl + 6 + (strip ? 0 : 4);
    lodd = (len >= 64) && (len % 2 == 1);
    hi   = ((len % 2 == 1) ? 8'h10 : 8'h00) | ((len > 1518) ? 8'h08 : 8'h00);
    expImg.push_back(8'h00); expImg.push_back(hi);
    expImg.push_back(8'(pkt & 255)); expImg.push_back(8'(pkt >> 8));
    for (int i = 0; i < len; i++) pay.push_back(dbyte(i, seed));
    while (pay.size() < 64) pay.push_back(8'h00);
    for (int i = 0; i < dl; i++) expImg.push_back(pay[i]);
    if (!strip) begin
      c = 32'hFFFFFFFF;
      foreach (pay[i]) begin
        c = c ^ {24'h0, pay[i]};
        for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
      end
      c = ~c;
      for (int j = 0; j < 4; j++) expImg.push_back(c[8*j +: 8]);
    end
    if (lodd) begin expImg.push_back(dbyte(len - 1, seed)); expImg.push_back(8'h60); end
    else      begin expImg.push_back(8'h00);                expImg.push_back(8'h40); end
    for (int i = 0; i < BUFB; i++) img[b][i] = 8'hEE;
    expBuf  = b;
    expPkt  = pkt;
    busyExp = 1'b1;
  endtask

  task automatic compare(input string req);
    int mism = 0, first = -1;
    for (int i = 0; i < expImg.size(); i++)
      if (img[expBuf][i] !== expImg[i]) begin mism++; if (first < 0) first = i; end
    if (first >= 0)
      check(1'b0, req, $sformatf("image byte %0d", first), img[expBuf][first], expImg[first]);
    else check(1'b1, req, "image", 0, 0);
    if (expPkt < BUFB)
      check(img[expBuf][expPkt] === 8'hEE, "R2", "byte past stored size", img[expBuf][expPkt], 8'hEE);
  endtask

  // every clock: writes go only to the expected buffer, inside the stored size
  always @(negedge clk) begin
    if (rstN && memWrEn) begin
      if (!busyExp) begin
        idleWrites++;
        check(1'b0, "R10", "write with no accepted frame", memAddr, 0);
      end else begin
        check(memBuf == 2'(expBuf), "R8", "write buffer", memBuf, expBuf);
        check(int'(memAddr) < expPkt, "R2", "write address", memAddr, expPkt);
        img[memBuf][memAddr] = memData;
      end
    end
    if (rstN && rxPush && !busyExp) check(1'b0, "R10", "unexpected push", 1, 0);
  end

  task automatic drive_bytes(input int len, input int seed, input int pokeAt);
    for (int i = 0; i < len; i++) begin
      frmValid = 1'b1; frmData = dbyte(i, seed); frmLast = (i == len - 1);
      frmStart = (i == pokeAt); frmLen = 12'd10;
      @(negedge clk);
      if (i == pokeAt)
        check(frmDrop && !allocTake, "R9", "start while busy", {frmDrop, allocTake}, 2'b10);
      @(posedge clk); #1;
    end
    frmValid = 1'b0; frmLast = 1'b0; frmStart = 1'b0;
  endtask

  task automatic wait_push(input int b);
    int n = 0;
    do begin @(negedge clk); n++; end while (!rxPush && n < 300);
    check(rxPush, "R8", "push seen", rxPush, 1);
    check(rxPushNum == 2'(b) && rcvIrqSet, "R8", "push number and irq", {rcvIrqSet, rxPushNum}, {1'b1, 2'(b)});
  endtask

  task automatic run_frame(input int len, input bit strip, input int b, input int seed,
                           input int pokeAt, input string req);
    prep(len, strip, b, seed);
    @(posedge clk); #1;
    cfgRxEnable = 1'b1; cfgSoftReset = 1'b0; cfgStripCrc = strip;
    frmStart = 1'b1; frmLen = LW'(len); allocValid = 1'b1; allocNum = 2'(b);
    @(negedge clk);
    check(allocTake && !frmDrop, "R1", "start accepted", {allocTake, frmDrop}, 2'b10);
    @(posedge clk); #1;
    frmStart = 1'b0; allocValid = 1'b0;
    drive_bytes(len, seed, pokeAt);
    wait_push(b);
    compare(req);
    @(posedge clk); #1;
    busyExp = 1'b0;
  endtask

  task automatic try_drop(input int len, input bit en, input bit srst, input bit strip,
                          input bit avail, input string req);
    int w0;
    @(posedge clk); #1;
    w0 = idleWrites;
    cfgRxEnable = en; cfgSoftReset = srst; cfgStripCrc = strip;
    frmStart = 1'b1; frmLen = LW'(len); allocValid = avail; allocNum = 2'd1;
    @(negedge clk);
    check(frmDrop && !allocTake, req, "start refused", {frmDrop, allocTake}, 2'b10);
    @(posedge clk); #1;
    frmStart = 1'b0; allocValid = 1'b0;
    for (int i = 0; i < 8; i++) begin
      frmValid = 1'b1; frmData = 8'(i); frmLast = (i == 7);
      @(posedge clk); #1;
    end
    frmValid = 1'b0; frmLast = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    check(idleWrites == w0, "R10", "bytes after refusal left storage untouched", idleWrites - w0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL R8 watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(!memWrEn && !rxPush && !allocTake && !frmDrop && !rcvIrqSet, "R8", "reset outputs quiet",
          {memWrEn, rxPush, allocTake, frmDrop, rcvIrqSet}, 0);

    run_frame(20,   1'b0, 0, 3,  -1, "R5 R6 short even with CRC");
    run_frame(33,   1'b1, 1, 9,  -1, "R5 R7 short odd stripped");
    run_frame(100,  1'b0, 2, 17, 5,  "R6 R9 long even, busy start");
    run_frame(101,  1'b0, 3, 21, -1, "R7 long odd with CRC");
    run_frame(75,   1'b1, 0, 40, -1, "R7 long odd stripped");
    run_frame(64,   1'b0, 1, 55, -1, "R5 exact minimum");
    run_frame(1519, 1'b0, 2, 77, -1, "R4 too-long odd status");
    run_frame(1518, 1'b1, 3, 88, -1, "R4 limit length status");
    run_frame(2043, 1'b1, 0, 99, -1, "R3 size exactly at buffer limit");

    try_drop(40,   1'b0, 1'b0, 1'b0, 1'b1, "R1");
    try_drop(40,   1'b1, 1'b1, 1'b0, 1'b1, "R1");
    try_drop(2044, 1'b1, 1'b0, 1'b1, 1'b1, "R3");
    try_drop(2040, 1'b1, 1'b0, 1'b0, 1'b1, "R3");
    try_drop(40,   1'b1, 1'b0, 1'b0, 1'b0, "R3");

    // R9: next start held high across the push cycle of the running frame
    prep(40, 1'b0, 1, 5);
    @(posedge clk); #1;
    cfgRxEnable = 1'b1; cfgSoftReset = 1'b0; cfgStripCrc = 1'b0;
    frmStart = 1'b1; frmLen = LW'(40); allocValid = 1'b1; allocNum = 2'd1;
    @(posedge clk); #1;
    frmStart = 1'b0;
    drive_bytes(40, 5, -1);
    frmStart = 1'b1; frmLen = LW'(70); allocValid = 1'b1; allocNum = 2'd2;
    cfgStripCrc = 1'b1;
    wait_push(1);
    check(frmDrop && !allocTake, "R9", "start in push cycle", {frmDrop, allocTake}, 2'b10);
    compare("R9 first frame of pair");
    prep(70, 1'b1, 2, 12);
    @(negedge clk);
    check(allocTake && !frmDrop, "R9", "start after push", {allocTake, frmDrop}, 2'b10);
    @(posedge clk); #1;
    frmStart = 1'b0; allocValid = 1'b0;
    drive_bytes(70, 12, -1);
    wait_push(2);
    compare("R9 second frame of pair");
    @(posedge clk); #1;
    busyExp = 1'b0;
    repeat (3) @(posedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule